// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Receive Queue

This block takes an asynchronous serial line and recovers characters from it using a clock enable that pulses at sixteen times the bit rate. Once a frame is recognised, the block strips the start, parity and stop bits and stores the character in a sixteen-entry queue. Each queue entry also holds three error flags: parity, framing and break. Because the flags are stored with the character, an error always stays attached to the character that caused it, even when several characters are waiting to be read.

The consumer reads the queue in show-ahead style. The oldest entry is always visible on the read port, and a one-cycle read strobe removes it. A sticky overrun flag reports any character that was lost because the queue was full. Configuration inputs set the word length and the parity mode. The receiver checks only the first stop bit. The configuration is expected to stay stable while a frame is in progress.

Top module: `serial_rx_queue`

## Requirements
- R1: An idle-high line is received as a start bit (low), then data bits with the least significant bit first, then an optional parity bit, then a stop bit (high). Each complete frame creates exactly one queue entry. The character sits in the low bits of `rdData`, and any unused upper bits read as zero.
- R2: `cfgWordLen` selects the number of data bits: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8.
- R3: When `cfgParEn` is 1, one parity bit follows the last data bit. The entry's parity flag is set when the count of ones in the data and parity bits is odd while `cfgParOdd` is 0, or even while `cfgParOdd` is 1. When `cfgParEn` is 0, the parity flag is 0.
- R4: A falling edge is taken as a start bit only if the line is still low at the 8th sampling enable after the edge was detected. Otherwise the receiver returns to idle and creates no entry.
- R5: Each data bit is sampled once, 16 enables after the previous sample. A stop bit that samples low sets the entry's framing flag.
- R6: A frame whose data, parity and stop bits all sample low is a break. It creates one entry with data 0, break flag 1, framing flag 1 and parity flag 0. The receiver accepts no new start bit until the line has returned high.
- R7: The queue holds 16 entries and returns them in arrival order. `dataReady` is high whenever the queue is non-empty, and `rdEn` removes the entry currently shown on the read port.
- R8: If a character completes while the queue holds 16 entries, that character is discarded and the stored entries are unchanged. `overrun` then goes high and stays high, even across reads, until `statusRd` is pulsed.
- R9: After reset the queue is empty, `dataReady` is 0 and `overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Sampling enable that pulses at 16 times the bit rate |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| cfgWordLen | input | 2 | Data bits per character, minus 5 |
| cfgParEn | input | 1 | 1 = a parity bit is present in each frame |
| cfgParOdd | input | 1 | 1 = odd parity, 0 = even parity |
| rdEn | input | 1 | Removes the oldest queue entry |
| statusRd | input | 1 | Clears the overrun flag |
| rdData | output | 8 | Character of the oldest entry |
| rdParErr | output | 1 | Parity flag of the oldest entry |
| rdFrmErr | output | 1 | Framing flag of the oldest entry |
| rdBreak | output | 1 | Break flag of the oldest entry |
| dataReady | output | 1 | Queue is not empty |
| overrun | output | 1 | Sticky flag: a character was lost to a full queue |

## Verification
The bench builds the block with its default parameters: 16 samples per bit and a queue depth of 16. At that depth, seventeen back-to-back frames are enough to fill the queue and push it into overrun. The enable pulses every second clock, so the test also shows that sampling advances only on enable cycles. A stop bit that samples low and is then followed by a short low tail creates a false start on its own, so the framing case also exercises start-bit rejection directly after a frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rxState_t;

  // Strobes issued by the controller to the datapath
  typedef struct packed {
    logic clrShift;
    logic shiftEn;
    logic bitVal;
    logic push;
    logic parErr;
    logic frmErr;
    logic brk;
  } rxStrobe_t;

  // One queue entry: the character plus its three error flags
  typedef struct packed {
    logic       brk;
    logic       frmErr;
    logic       parErr;
    logic [7:0] data;
  } rxEntry_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       serialIn,
  input  logic [1:0] cfgWordLen,
  input  logic       cfgParEn,
  input  logic       cfgParOdd,
  output rxStrobe_t  stb
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);

  logic [1:0]    syncQ;
  logic          rxBit;
  rxState_t      state, nState;
  logic [CW-1:0] cnt;
  logic [2:0]    bitIdx;
  logic          parAcc, allZero, lastTick, isBreak;
  logic [2:0]    lastIdx;

  // Two-flop synchroniser on the asynchronous line (resets to idle high)
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], serialIn};
  assign rxBit = syncQ[1];

  assign lastTick = (cnt == LAST_CNT);
  assign lastIdx  = 3'd4 + {1'b0, cfgWordLen};
  assign isBreak  = allZero && !rxBit;

  always_comb begin
    stb        = '0;
    stb.bitVal = rxBit;
    nState     = state;
    if (tickEn) begin
      case (state)
        ST_IDLE:  if (!rxBit) nState = ST_START;
        ST_START: if (cnt == MID_CNT) begin
                    if (rxBit) nState = ST_IDLE;
                    else begin
                      nState       = ST_DATA;
                      stb.clrShift = 1'b1;
                    end
                  end
        ST_DATA:  if (lastTick) begin
                    stb.shiftEn = 1'b1;
                    if (bitIdx == lastIdx) nState = cfgParEn ? ST_PAR : ST_STOP;
                  end
        ST_PAR:   if (lastTick) nState = ST_STOP;
        ST_STOP:  if (lastTick) begin
                    stb.push   = 1'b1;
                    stb.brk    = isBreak;
                    stb.frmErr = !rxBit;
                    stb.parErr = cfgParEn && !isBreak && (parAcc != cfgParOdd);
                    nState     = isBreak ? ST_HOLD : ST_IDLE;
                  end
        ST_HOLD:  if (rxBit) nState = ST_IDLE;
        default:  nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      parAcc  <= 1'b0;
      allZero <= 1'b1;
    end else if (tickEn) begin
      state <= nState;
      case (state)
        ST_IDLE, ST_HOLD: cnt <= '0;
        ST_START: cnt <= (cnt == MID_CNT) ? '0 : cnt + 1'b1;
        default:  cnt <= lastTick ? '0 : cnt + 1'b1;
      endcase
      if (stb.clrShift) begin
        bitIdx  <= '0;
        parAcc  <= 1'b0;
        allZero <= 1'b1;
      end else if (stb.shiftEn || (state == ST_PAR && lastTick)) begin
        bitIdx  <= bitIdx + 1'b1;
        parAcc  <= parAcc ^ rxBit;
        if (rxBit) allZero <= 1'b0;
      end
    end
  end

  // A frame never yields two entries in a row
  AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |=> !stb.push); // R1
  // After a break, a low line keeps the receiver parked
  AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !rxBit) |=> state == ST_HOLD); // R6
  // Rejected start: START never jumps straight to a push
  AST_FALSE_START_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START) |-> !stb.push); // R4
endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobe_t  stb,
  input  logic [1:0] cfgWordLen,
  input  logic       rdEn,
  input  logic       statusRd,
  output rxEntry_t   head,
  output logic       dataReady,
  output logic       overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [NW-1:0] FULL_CNT = NW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [7:0]    shReg, aligned;
  rxEntry_t      mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [NW-1:0] count;
  logic          full, doPush, doPop;
  rxEntry_t      wEntry;

  // Bits enter at the top, so a short word has to be moved down
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             shReg <= '0;
    else if (stb.clrShift) shReg <= '0;
    else if (stb.shiftEn)  shReg <= {stb.bitVal, shReg[7:1]};

  assign aligned = shReg >> (2'd3 - cfgWordLen);
  assign wEntry  = '{brk: stb.brk, frmErr: stb.frmErr, parErr: stb.parErr,
                     data: aligned};

  assign full   = (count == FULL_CNT);
  assign doPush = stb.push && !full;
  assign doPop  = rdEn && (count != '0);

  always_ff @(posedge clk)
    if (doPush) mem[wrPtr] <= wEntry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      count <= count + NW'(doPush) - NW'(doPop);
      if (stb.push && full) overrun <= 1'b1;
      else if (statusRd)    overrun <= 1'b0;
    end
  end

  assign head      = mem[rdPtr];
  assign dataReady = (count != '0);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R7
  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && full && !rdEn) |=> full && $stable(wrPtr)); // R8
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && full) |=> overrun); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !statusRd) |=> overrun); // R8
  AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && stb.brk) |-> (aligned == 8'h00)); // R6
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import serial_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       serialIn,
  input  logic [1:0] cfgWordLen,
  input  logic       cfgParEn,
  input  logic       cfgParOdd,
  input  logic       rdEn,
  input  logic       statusRd,
  output logic [7:0] rdData,
  output logic       rdParErr,
  output logic       rdFrmErr,
  output logic       rdBreak,
  output logic       dataReady,
  output logic       overrun
);
  rxStrobe_t stb;
  rxEntry_t  head;

  serial_rx_ctrl #(.OSR(OSR)) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .serialIn(serialIn),
    .cfgWordLen(cfgWordLen), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .stb(stb)
  );

  serial_rx_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgWordLen(cfgWordLen),
    .rdEn(rdEn), .statusRd(statusRd), .head(head),
    .dataReady(dataReady), .overrun(overrun)
  );

  assign rdData   = head.data;
  assign rdParErr = head.parErr;
  assign rdFrmErr = head.frmErr;
  assign rdBreak  = head.brk;
endmodule

// File: tb/sim_serial_rx_queue.sv
module sim_serial_rx_queue;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32; // 16 enables per bit, enable every 2nd clock

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, serialIn = 1'b1;
  logic [1:0] cfgWordLen = 2'd3;
  logic cfgParEn = 1'b0, cfgParOdd = 1'b0, rdEn = 1'b0, statusRd = 1'b0;
  logic [7:0] rdData;
  logic rdParErr, rdFrmErr, rdBreak, dataReady, overrun;

  int nTests = 0, nFail = 0;
  bit monEn = 1'b1;
  logic [10:0] expQ[$];
  string       tagQ[$];

  serial_rx_queue u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .serialIn(serialIn),
    .cfgWordLen(cfgWordLen), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .rdEn(rdEn), .statusRd(statusRd), .rdData(rdData), .rdParErr(rdParErr),
    .rdFrmErr(rdFrmErr), .rdBreak(rdBreak), .dataReady(dataReady),
    .overrun(overrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  initial forever begin @(negedge clk); tickEn = ~tickEn; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops the queue and compares against the scoreboard
  initial forever begin
    @(negedge clk);
    if (monEn && dataReady) begin
      if (expQ.size() == 0) chk("R7 unexpected entry", {21'd0, rdBreak, rdFrmErr, rdParErr, rdData}, 32'hFFFF);
      else begin
        logic [10:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, {21'd0, rdBreak, rdFrmErr, rdParErr, rdData}, {21'd0, e});
      end
      rdEn = 1'b1;
    end else rdEn = 1'b0;
  end

  task automatic sendBit(input logic b);
    serialIn = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // flags = {brk, frm, par}; expectation is pushed only when pushExp is set
  task automatic sendFrame(input logic [7:0] d, input bit flipPar, input bit stopVal,
                           input bit pushExp, input string tag);
    int nb;
    logic [7:0] m;
    logic pb;
    nb = 5 + int'(cfgWordLen);
    m  = d & 8'((1 << nb) - 1);
    pb = (^m) ^ cfgParOdd ^ flipPar;
    if (pushExp) begin
      expQ.push_back({1'b0, !stopVal, cfgParEn & flipPar, m});
      tagQ.push_back(tag);
    end
    sendBit(1'b0);
    for (int i = 0; i < nb; i++) sendBit(m[i]);
    if (cfgParEn) sendBit(pb);
    sendBit(stopVal);
    serialIn = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && expQ.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R7 scoreboard drained", expQ.size(), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 dataReady after reset", dataReady, 0);
    chk("R9 overrun after reset", overrun, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 eight bits, no parity
    sendFrame(8'h55, 0, 1, 1, "R1 8N1 0x55");
    sendFrame(8'hA3, 0, 1, 1, "R1 8N1 0xA3");
    sendFrame(8'h80, 0, 1, 1, "R1 8N1 0x80");
    // R2 word lengths
    cfgWordLen = 2'd0; sendFrame(8'hFF, 0, 1, 1, "R2 5-bit");
    cfgWordLen = 2'd1; sendFrame(8'h2A, 0, 1, 1, "R2 6-bit");
    cfgWordLen = 2'd2; sendFrame(8'h7F, 0, 1, 1, "R2 7-bit");
    cfgWordLen = 2'd3;
    // R3 parity
    cfgParEn = 1'b1; cfgParOdd = 1'b0;
    sendFrame(8'h37, 0, 1, 1, "R3 even ok");
    sendFrame(8'h37, 1, 1, 1, "R3 even error");
    cfgParOdd = 1'b1;
    sendFrame(8'hC1, 0, 1, 1, "R3 odd ok");
    sendFrame(8'hC1, 1, 1, 1, "R3 odd error");
    cfgWordLen = 2'd1;
    sendFrame(8'h15, 1, 1, 1, "R3 6-bit odd error");
    cfgWordLen = 2'd3; cfgParEn = 1'b0; cfgParOdd = 1'b0;
    drain();

    // R4 false start: short low glitch
    serialIn = 1'b0; repeat (8) @(negedge clk);
    serialIn = 1'b1; repeat (4 * BIT_CLKS) @(negedge clk);
    chk("R4 glitch gives no entry", dataReady, 0);
    sendFrame(8'h3C, 0, 1, 1, "R4 frame after glitch");

    // R5 framing: stop low, trailing low half-bit also rejected as start
    sendFrame(8'h01, 0, 0, 1, "R5 framing error");
    sendFrame(8'h9E, 0, 1, 1, "R5 clean after framing");
    drain();

    // R6 break: line low well beyond a frame
    expQ.push_back(11'b110_0000_0000); tagQ.push_back("R6 break entry");
    serialIn = 1'b0; repeat (14 * BIT_CLKS) @(negedge clk);
    drain();
    chk("R6 no start while line held low", dataReady, 0);
    serialIn = 1'b1; repeat (2 * BIT_CLKS) @(negedge clk);
    sendFrame(8'h66, 0, 1, 1, "R6 frame after break");
    drain();

    // R8 overrun: 17 frames with reads disabled
    monEn = 1'b0;
    for (int i = 0; i < 17; i++)
      sendFrame(8'(8'h30 + i), 0, 1, i < 16, "R8 stored entry");
    chk("R8 overrun set", overrun, 1);
    chk("R7 dataReady while full", dataReady, 1);
    monEn = 1'b1;
    drain();
    chk("R8 17th discarded", dataReady, 0);
    chk("R8 overrun survives reads", overrun, 1);
    statusRd = 1'b1; @(negedge clk); statusRd = 1'b0;
    chk("R8 overrun cleared by statusRd", overrun, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule